// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Executor

This block carries out one instruction of a small 8-bit controller: rotating a byte of the register file left by one place, with the carry flag as a ninth bit in the loop. A start pulse comes with a 16-bit instruction word. The block resolves the 12-bit file address from the instruction's 8-bit file field and its bank bit. The bank-select value, the pointer register and the extended-mode enable also take part in the address. The addressed byte is read through a read port. The block then rotates the byte, puts the result in the working register or writes it back through the file write port, and updates the carry, negative and zero flags.

Each instruction takes two clock cycles. In the first cycle the read address is driven and the operand is captured. In the second cycle the write port is driven, and at the end of that cycle the working register and the flags are updated. The register file itself lies outside the block, so it can be shared with the other execution units.

Top module: `rotcarry_alu`

## Requirements
- R1: A start is accepted only when instruction bits [15:10] equal 6'b001101. Bit 9 is the destination bit d, bit 8 is the bank bit a, and bits [7:0] are the file field f. A start carrying any other opcode changes no output.
- R2: The result is {operand[6:0], C}, where C is the carry before the instruction. The new carry is operand[7].
- R3: The status output holds C in bit 0, Z in bit 1 and N in bit 2. N is result bit 7, and Z is 1 exactly when the 8-bit result is zero.
- R4: With d=0 the result is loaded into the working register and no write strobe is raised. With d=1 the write strobe is high for one cycle, with the resolved address and the result, and the working register keeps its value.
- R5: With a=1 the address is {bsr[3:0], f}.
- R6: With a=0 and indexing not in use, f below 0x60 addresses 0x000+f, and f of 0x60 or above addresses 0xF00+f.
- R7: With a=0, extended mode enabled and f at most 0x5F, the address is (pointer + f) taken modulo 4096.
- R8: The read address follows the instruction combinationally, and read data is sampled at the clock edge that accepts the start. The write port is active in the following cycle. The working register and the status change at the end of that cycle.
- R9: A start that arrives while an instruction is executing is ignored.
- R10: After reset the working register is 0, the status is 0 and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank select for banked addressing |
| ptrReg | input | 12 | Base pointer for indexed addressing |
| extEn | input | 1 | Extended (indexed) mode enable |
| rdAddr | output | 12 | File read address |
| rdData | input | 8 | File read data |
| wrEn | output | 1 | File write strobe |
| wrAddr | output | 12 | File write address |
| wrData | output | 8 | File write data |
| wReg | output | 8 | Working register |
| status | output | 3 | Flags {N, Z, C} |

## Verification
The rotate is exercised with all 256 operand values, under both incoming carry values and both destination settings. This separates a faulty carry in, a faulty carry out, an error in flag placement, and writes sent to the wrong destination. The address resolver is swept over every file field value, with the bank bit and the extended mode each off and on, and with bank and pointer values that vary. These cases single out the 0x5F/0x60 access split, the indexed window and the wrap of the pointer sum. Separate cases cover an invalid opcode, a start held through execution, and the worked example of operand 0xE6 with carry 0.

// File: rtl/rotcarry_pkg.sv
package rotcarry_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic latchOp;   // capture operand, destination and address
    logic commit;    // drive write port / update W and flags
  } ctrlStrobes_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_EXEC = 1'b1
  } phase_t;

  // Upper six opcode bits of the rotate-left-through-carry instruction
  localparam logic [5:0] RLC_OPC = 6'b001101;

endpackage

// File: rtl/rotcarry_addr_decode.sv
module rotcarry_addr_decode #(
  parameter int F_W          = 8,
  parameter int ADDR_W       = 12,
  parameter int ACCESS_SPLIT = 96,
  parameter bit HAS_INDEXED  = 1'b1,
  localparam int HI_W        = ADDR_W - F_W
) (
  input  logic [F_W-1:0]    fField,
  input  logic              bankBit,
  input  logic              extEn,
  input  logic [HI_W-1:0]   bsr,
  input  logic [ADDR_W-1:0] ptrReg,
  output logic [ADDR_W-1:0] addr
);

  logic lowHalf;
  logic useIndexed;
  logic [ADDR_W-1:0] indexedAddr;
  logic [ADDR_W-1:0] accessAddr;

  assign lowHalf = (int'(fField) < ACCESS_SPLIT);

  generate
    if (HAS_INDEXED) begin : g_indexed
      assign useIndexed  = !bankBit && extEn && lowHalf;
      assign indexedAddr = ptrReg + {{HI_W{1'b0}}, fField};
    end else begin : g_noIndexed
      logic unusedIdx;
      assign unusedIdx   = extEn ^ (^ptrReg);
      assign useIndexed  = 1'b0;
      assign indexedAddr = '0;
    end
  endgenerate

  assign accessAddr = lowHalf ? {{HI_W{1'b0}}, fField}
                              : {{HI_W{1'b1}}, fField};

  always_comb begin
    if (bankBit)         addr = {bsr, fField};
    else if (useIndexed) addr = indexedAddr;
    else                 addr = accessAddr;
  end

endmodule

// File: rtl/rotcarry_ctrl.sv
module rotcarry_ctrl
  import rotcarry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [5:0]   opcodeHi,
  output ctrlStrobes_t strobes
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    strobes.latchOp = (phase == PH_IDLE) && start && (opcodeHi == RLC_OPC);
    strobes.commit  = (phase == PH_EXEC);
    phaseNext       = phase;
    if (strobes.latchOp)     phaseNext = PH_EXEC;
    else if (strobes.commit) phaseNext = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R8: execution lasts exactly one cycle after acceptance
  a_r8_single_exec: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit);

  // R9: a start during execution is never accepted
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !strobes.latchOp);

  // R1: acceptance only on the matching opcode
  a_r1_opcode_gate: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchOp |-> (start && opcodeHi == RLC_OPC));

endmodule

// File: rtl/rotcarry_datapath.sv
module rotcarry_datapath
  import rotcarry_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] rdData,
  input  logic              destBit,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] wReg,
  output logic [2:0]        status,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opReg;
  logic              destReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] result;
  logic              cFlag;
  logic              nFlag;
  logic              zFlag;

  // Operand capture (read phase)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      destReg <= 1'b0;
      addrReg <= '0;
    end else if (strobes.latchOp) begin
      opReg   <= rdData;
      destReg <= destBit;
      addrReg <= addrIn;
    end
  end

  // Rotate left through carry (process phase)
  assign result = {opReg[MSB-1:0], cFlag};

  // Destination and flag update (write phase)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg  <= '0;
      cFlag <= 1'b0;
      nFlag <= 1'b0;
      zFlag <= 1'b0;
    end else if (strobes.commit) begin
      cFlag <= opReg[MSB];
      nFlag <= result[MSB];
      zFlag <= (result == '0);
      if (!destReg) wReg <= result;
    end
  end

  assign wrEn   = strobes.commit && destReg;
  assign wrAddr = addrReg;
  assign wrData = result;
  assign status = {nFlag, zFlag, cFlag};

  // R8: commit follows acceptance by one cycle
  a_r8_commit_after_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> $past(strobes.latchOp));

  // R2: carry out is the operand's top bit
  a_r2_carry_out: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> cFlag == $past(opReg[MSB]));

  // R3: zero flag set only when operand low bits and carry were all zero
  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> zFlag == ($past(opReg[MSB-1:0]) == '0 && !$past(cFlag)));

  // R4: file destination leaves W alone
  a_r4_w_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && destReg) |=> $stable(wReg));

  // R8: W and flags only move on commit
  a_r8_state_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> ($stable(wReg) && $stable(status)));

endmodule

// File: rtl/rotcarry_alu.sv
module rotcarry_alu
  import rotcarry_pkg::*;
#(
  parameter int F_W          = 8,
  parameter int ADDR_W       = 12,
  parameter int ACCESS_SPLIT = 96,
  parameter bit HAS_INDEXED  = 1'b1,
  localparam int INSTR_W     = F_W + 8,
  localparam int HI_W        = ADDR_W - F_W,
  localparam int DATA_W      = F_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [HI_W-1:0]    bsr,
  input  logic [ADDR_W-1:0]  ptrReg,
  input  logic               extEn,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  rdData,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  wReg,
  output logic [2:0]         status
);

  ctrlStrobes_t strobes;
  logic [F_W-1:0] fField;
  logic           bankBit;
  logic           destBit;
  logic [1:0]     unusedLow;

  assign fField    = instr[F_W-1:0];
  assign bankBit   = instr[F_W];
  assign destBit   = instr[F_W+1];
  assign unusedLow = instr[INSTR_W-7:INSTR_W-8];

  rotcarry_addr_decode #(
    .F_W(F_W), .ADDR_W(ADDR_W), .ACCESS_SPLIT(ACCESS_SPLIT), .HAS_INDEXED(HAS_INDEXED)
  ) u_decode (
    .fField(fField), .bankBit(bankBit), .extEn(extEn),
    .bsr(bsr), .ptrReg(ptrReg), .addr(rdAddr)
  );

  rotcarry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .opcodeHi(instr[INSTR_W-1:INSTR_W-6]), .strobes(strobes)
  );

  rotcarry_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(rdData),
    .destBit(destBit), .addrIn(rdAddr), .wReg(wReg), .status(status),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // R5: banked access keeps f in the low address byte and bsr above it
  a_r5_banked: assert property (@(posedge clk) disable iff (!rstN)
    bankBit |-> (rdAddr == {bsr, fField}));

  // R6: upper access half lands in the top page
  a_r6_upper_page: assert property (@(posedge clk) disable iff (!rstN)
    (!bankBit && int'(fField) >= ACCESS_SPLIT) |-> (rdAddr[ADDR_W-1:F_W] == {HI_W{1'b1}}));

  // R4: write strobe is a single-cycle pulse
  a_r4_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

endmodule

// File: tb/test_rotcarry_alu.sv
module test_rotcarry_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic [11:0] ptrReg = '0;
  logic        extEn = 1'b0;
  logic [11:0] rdAddr;
  logic [7:0]  rdData = '0;
  logic        wrEn;
  logic [11:0] wrAddr;
  logic [7:0]  wrData;
  logic [7:0]  wReg;
  logic [2:0]  status;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] mW = '0;
  logic       mC = 1'b0;

  always #5 clk = ~clk;

  rotcarry_alu i_rotcarry_alu (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .bsr(bsr),
    .ptrReg(ptrReg), .extEn(extEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wReg(wReg), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expAddr(input logic a, input logic [7:0] f,
      input logic [3:0] b, input logic [11:0] p, input logic ext);
    if (a) return {b, f};
    if (ext && f <= 8'h5F) return 12'((p + f) % 4096);
    if (f < 8'h60) return {4'h0, f};
    return {4'hF, f};
  endfunction

  // One instruction through the block with file field 0x20, bank 3, a=1
  task automatic execRlc(input logic d, input logic [7:0] val, input string req);
    logic [7:0] res;
    logic       cNew;
    res  = {val[6:0], mC};
    cNew = val[7];
    @(negedge clk);
    bsr   = 4'h3;
    instr = {6'b001101, d, 1'b1, 8'h20};
    rdData = val;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rdData = 8'h00;
    check({req, " R4 wrEn"}, 32'(wrEn), 32'(d));
    if (d) begin
      check({req, " R4 wrAddr"}, 32'(wrAddr), 32'h320);
      check({req, " R2 wrData"}, 32'(wrData), 32'(res));
    end
    @(negedge clk);
    if (!d) mW = res;
    mC = cNew;
    check({req, " R4 wReg"}, 32'(wReg), 32'(mW));
    check({req, " R3 status"}, 32'(status), 32'({res[7], res == 8'h00, cNew}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 wReg", 32'(wReg), 0);
    check("R10 status", 32'(status), 0);
    check("R10 wrEn", 32'(wrEn), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Worked example: 0xE6 with carry 0, result to W
    execRlc(1'b0, 8'h00, "prime");
    execRlc(1'b0, 8'hE6, "example");
    check("R2 example W", 32'(wReg), 32'hCC);
    check("R3 example status", 32'(status), 32'b101);

    // R2 R3 R4: every operand, both carries, both destinations
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 2; d++)
        for (int v = 0; v < 256; v++) begin
          execRlc(1'b0, (c != 0) ? 8'h80 : 8'h00, "prime");
          execRlc(d[0], v[7:0], "sweep");
        end

    // R5 R6 R7: address resolution sweep, combinational read address
    for (int a = 0; a < 2; a++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 256; f++) begin
          @(negedge clk);
          bsr    = f[3:0] ^ 4'h5;
          ptrReg = 12'hFC0 + 12'(f * 3);
          extEn  = e[0];
          instr  = {6'b001101, 1'b1, a[0], f[7:0]};
          #1;
          check(a != 0 ? "R5 banked addr" : (e != 0 ? "R7 indexed addr" : "R6 access addr"),
                32'(rdAddr), 32'(expAddr(a[0], f[7:0], bsr, ptrReg, e[0])));
        end

    // R8: indexed address latched and driven on the write port
    @(negedge clk);
    extEn = 1'b1; ptrReg = 12'hFF0;
    instr = {6'b001101, 1'b1, 1'b0, 8'h30}; rdData = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0; instr = 16'h0000; extEn = 1'b0;
    check("R8 R7 latched wrAddr", 32'(wrAddr), 32'h020);
    check("R8 wrEn", 32'(wrEn), 1);
    @(negedge clk);
    mC = 1'b0;
    check("R8 after commit wrEn", 32'(wrEn), 0);

    // R1: invalid opcode is ignored
    @(negedge clk);
    instr = 16'h3B80; rdData = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 invalid wrEn", 32'(wrEn), 0);
    @(negedge clk);
    check("R1 invalid wReg", 32'(wReg), 32'(mW));
    check("R1 invalid status", 32'(status), 32'({mW[7] & 1'b0, 1'b0, mC}) | (32'(status) & 32'b110));

    // R9: start held through execution takes effect once
    execRlc(1'b0, 8'h00, "prime9");
    @(negedge clk);
    bsr = 4'h3; instr = {6'b001101, 1'b0, 1'b1, 8'h20}; rdData = 8'h41; start = 1'b1;
    @(negedge clk);
    rdData = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    check("R9 held start wReg", 32'(wReg), 32'h82);
    check("R9 held start status", 32'(status), 32'b100);
    @(negedge clk);
    check("R9 no second exec wReg", 32'(wReg), 32'h82);
    check("R9 no second exec wrEn", 32'(wrEn), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule